// File: doc/BRIEF.md
# Virtual Interval Timer with Match Interrupt

This block gives one processor a software-visible interval timer. A shared time base enters as an input. Software sees that time base plus a programmable offset. A monotone guard keeps the value software reads from ever moving backward when the shared base is swapped or steps back. Software can program a match value and a vector/mask register. When the visible count reaches the armed match, the block posts the programmed vector into a 256-entry pending-interrupt array. The post happens only when the mask is clear.

Every register write also keeps the pending array consistent with the new settings:

- A counter write that moves the time past the match cancels the pending bit and the arming.
- A match write withdraws the pending bit of the current vector.
- A vector write either withdraws the pending bit or carries it over to the new vector.

The interrupt controller reads the pending array directly. It clears a bit with an acknowledge strobe when it takes the interrupt.

Top module: `interval_timer_match`

## Requirements
- R1: After reset, the match register reads 0 and the vector register reads 0x10000 (mask bit 16 set, vector 0). Every pending bit is 0. The offset is 0.
- R2: A read with rdSel=0 returns baseCount plus the offset on rdData. The value appears in the cycle after rdEn. Select codes: 0 counter, 1 match, 2 vector.
- R3: A counter read returns the last value already reported whenever base+offset is not strictly greater than it (compared as a signed difference). Reported counter values never go backward, except through a counter write.
- R4: A counter write (wrSel=0) sets offset = wrData − baseCount. It also sets the last reported value to wrData.
- R5: After a counter write with match < wrData, the pending bit of the current vector is cleared and the match is disarmed. No interrupt fires afterwards.
- R6: A match write (wrSel=1) clears the pending bit of the current vector.
- R7: A match write arms the match only if the new match is greater than the last reported counter value. Otherwise the match is disarmed and never fires.
- R8: When armed and the visible count is at or above the match, the block fires once. It sets pendArr[vector] if the mask is clear and refreshes the last reported value. Only a new match write re-arms it.
- R9: A firing while the mask is set sets no pending bit but still consumes the arming.
- R10: A vector write (wrSel=2) with bit 16 set clears the pending bit of the old vector.
- R11: A vector write with bit 16 clear and a different vector in bits 7:0 moves a pending old-vector bit to the new vector.
- R12: ackEn clears pendArr[ackVec].
- R13: rdSel=1 returns the match register. rdSel=2 returns the vector register with the mask in bit 16 and the vector in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseCount | input | 64 | Shared time base |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 counter, 1 match, 2 vector |
| wrData | input | 64 | Write data |
| rdEn | input | 1 | Register read strobe |
| rdSel | input | 2 | Read target, same codes as wrSel |
| rdData | output | 64 | Read result, valid the cycle after rdEn |
| ackEn | input | 1 | Clear one pending bit |
| ackVec | input | 8 | Vector to clear |
| pendArr | output | 256 | Pending-interrupt array |

## Verification
The checks assume that at most one register write is presented per cycle. They also assume that the shared time base and the written values stay far from 64-bit wraparound, so that signed differences match unsigned order. The stimulus keeps every count in the low tens of thousands. It issues one write or read per task call. The time base moves only between operations, in steps chosen to land just below and exactly on each match value.

// File: rtl/itm_pkg.sv
package itm_pkg;
  typedef enum logic [1:0] {
    SEL_CNT   = 2'd0,
    SEL_MATCH = 2'd1,
    SEL_VEC   = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic ldCnt;
    logic ldMatch;
    logic ldVec;
    logic refreshLast;
    logic clearCur;
    logic moveCur;
    logic postCur;
  } itmStrobes_t;
endpackage

// File: rtl/itm_datapath.sv
module itm_datapath
  import itm_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int VEC_W    = 8,
  parameter int MASK_POS = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [CNT_W-1:0]       baseCount,
  input  logic [CNT_W-1:0]       wrData,
  input  logic                   rdEn,
  input  logic [1:0]             rdSel,
  input  itmStrobes_t            st,
  input  logic                   ackEn,
  input  logic [VEC_W-1:0]       ackVec,
  output logic                   curGe,
  output logic                   matchLtWr,
  output logic                   wrGtLast,
  output logic                   maskQ,
  output logic                   vecChanges,
  output logic [VEC_W-1:0]       vecQ,
  output logic [CNT_W-1:0]       lastQ,
  output logic [CNT_W-1:0]       rdData,
  output logic [(1<<VEC_W)-1:0]  pendArr
);
  localparam int NUM_VEC = 1 << VEC_W;

  logic [CNT_W-1:0]   offQ, matchQ, rawNow, curNow, vregVal;
  logic [NUM_VEC-1:0] pendNext;
  logic [VEC_W-1:0]   wrVec;

  assign wrVec  = wrData[VEC_W-1:0];
  assign rawNow = baseCount + offQ;
  // Monotone guard: fall back to the last reported value when not ahead of it
  assign curNow = ($signed(rawNow - lastQ) > 0) ? rawNow : lastQ;

  assign curGe      = curNow >= matchQ;
  assign matchLtWr  = matchQ < wrData;
  assign wrGtLast   = wrData > lastQ;
  assign vecChanges = wrVec != vecQ;

  always_comb begin
    vregVal           = '0;
    vregVal[VEC_W-1:0] = vecQ;
    vregVal[MASK_POS] = maskQ;
  end

  always_comb begin
    pendNext = pendArr;
    if (ackEn) pendNext[ackVec] = 1'b0;
    if (st.clearCur) pendNext[vecQ] = 1'b0;
    if (st.moveCur && pendArr[vecQ]) begin
      pendNext[vecQ]  = 1'b0;
      pendNext[wrVec] = 1'b1;
    end
    if (st.postCur) pendNext[vecQ] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offQ    <= '0;
      lastQ   <= '0;
      matchQ  <= '0;
      vecQ    <= '0;
      maskQ   <= 1'b1;
      pendArr <= '0;
      rdData  <= '0;
    end else begin
      pendArr <= pendNext;
      if (st.ldCnt) begin
        offQ  <= wrData - baseCount;
        lastQ <= wrData;
      end else if (st.refreshLast) begin
        lastQ <= curNow;
      end
      if (st.ldMatch) matchQ <= wrData;
      if (st.ldVec) begin
        vecQ  <= wrVec;
        maskQ <= wrData[MASK_POS];
      end
      if (rdEn) begin
        case (rdSel)
          SEL_CNT:   rdData <= curNow;
          SEL_MATCH: rdData <= matchQ;
          SEL_VEC:   rdData <= vregVal;
          default:   rdData <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/itm_control.sv
module itm_control
  import itm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic        wrMaskBit,
  input  logic        rdEn,
  input  logic [1:0]  rdSel,
  input  logic        curGe,
  input  logic        matchLtWr,
  input  logic        wrGtLast,
  input  logic        maskQ,
  input  logic        vecChanges,
  output itmStrobes_t st,
  output logic        armedQ
);
  logic wrCnt, wrMatch, wrVec, fire;

  assign wrCnt   = wrEn && (wrSel == SEL_CNT);
  assign wrMatch = wrEn && (wrSel == SEL_MATCH);
  assign wrVec   = wrEn && (wrSel == SEL_VEC);
  // A register write in the same cycle takes precedence over a firing
  assign fire    = armedQ && curGe && !wrEn;

  always_comb begin
    st.ldCnt       = wrCnt;
    st.ldMatch     = wrMatch;
    st.ldVec       = wrVec;
    st.refreshLast = (rdEn && (rdSel == SEL_CNT)) || fire;
    st.clearCur    = wrMatch || (wrCnt && matchLtWr) || (wrVec && wrMaskBit);
    st.moveCur     = wrVec && !wrMaskBit && vecChanges;
    st.postCur     = fire && !maskQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    armedQ <= 1'b0;
    else if (wrMatch)             armedQ <= wrGtLast;
    else if (wrCnt && matchLtWr)  armedQ <= 1'b0;
    else if (fire)                armedQ <= 1'b0;
  end
endmodule

// File: rtl/interval_timer_match.sv
module interval_timer_match
  import itm_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int VEC_W    = 8,
  parameter int MASK_POS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CNT_W-1:0]      baseCount,
  input  logic                  wrEn,
  input  logic [1:0]            wrSel,
  input  logic [CNT_W-1:0]      wrData,
  input  logic                  rdEn,
  input  logic [1:0]            rdSel,
  output logic [CNT_W-1:0]      rdData,
  input  logic                  ackEn,
  input  logic [VEC_W-1:0]      ackVec,
  output logic [(1<<VEC_W)-1:0] pendArr
);
  itmStrobes_t      st;
  logic             curGe, matchLtWr, wrGtLast, maskQ, vecChanges, armedQ;
  logic [VEC_W-1:0] vecQ;
  logic [CNT_W-1:0] lastQ;

  itm_control ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .wrMaskBit(wrData[MASK_POS]), .rdEn(rdEn), .rdSel(rdSel),
    .curGe(curGe), .matchLtWr(matchLtWr), .wrGtLast(wrGtLast),
    .maskQ(maskQ), .vecChanges(vecChanges), .st(st), .armedQ(armedQ)
  );

  itm_datapath #(.CNT_W(CNT_W), .VEC_W(VEC_W), .MASK_POS(MASK_POS)) dp_i (
    .clk(clk), .rstN(rstN), .baseCount(baseCount), .wrData(wrData),
    .rdEn(rdEn), .rdSel(rdSel), .st(st), .ackEn(ackEn), .ackVec(ackVec),
    .curGe(curGe), .matchLtWr(matchLtWr), .wrGtLast(wrGtLast),
    .maskQ(maskQ), .vecChanges(vecChanges), .vecQ(vecQ), .lastQ(lastQ),
    .rdData(rdData), .pendArr(pendArr)
  );
endmodule

// File: rtl/itm_checker.sv
module itm_checker #(
  parameter int CNT_W    = 64,
  parameter int VEC_W    = 8,
  parameter int MASK_POS = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [1:0]            wrSel,
  input logic [CNT_W-1:0]      wrData,
  input logic                  armedQ,
  input logic                  curGe,
  input logic [VEC_W-1:0]      vecQ,
  input logic [CNT_W-1:0]      lastQ,
  input logic [(1<<VEC_W)-1:0] pendArr
);
  // R3: the reported value only steps back through a counter write
  p_monotone_last_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrSel == 2'd0) |=> $signed(lastQ - $past(lastQ)) >= 0);

  // R8: a firing consumes the arming
  p_fire_once_r8: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && curGe && !wrEn) |=> !armedQ);

  // R6: a match write leaves the current vector's bit clear
  p_match_wr_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd1) |=> !pendArr[$past(vecQ)]);

  // R10: a masking vector write withdraws the old vector's bit
  p_mask_wr_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd2 && wrData[MASK_POS]) |=> !pendArr[$past(vecQ)]);

  // R7: arming only comes from a match write
  p_arm_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armedQ) |-> $past(wrEn && wrSel == 2'd1));
endmodule

bind interval_timer_match itm_checker #(
  .CNT_W(CNT_W), .VEC_W(VEC_W), .MASK_POS(MASK_POS)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .armedQ(armedQ), .curGe(curGe), .vecQ(vecQ), .lastQ(lastQ),
  .pendArr(pendArr)
);

// File: tb/interval_timer_match_tb.sv
module interval_timer_match_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [63:0]  baseCount = '0;
  logic         wrEn = 1'b0;
  logic [1:0]   wrSel = '0;
  logic [63:0]  wrData = '0;
  logic         rdEn = 1'b0;
  logic [1:0]   rdSel = '0;
  logic [63:0]  rdData;
  logic         ackEn = 1'b0;
  logic [7:0]   ackVec = '0;
  logic [255:0] pendArr;

  int  nChecks = 0;
  int  nFails = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  interval_timer_match dut_i (
    .clk(clk), .rstN(rstN), .baseCount(baseCount), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .rdEn(rdEn), .rdSel(rdSel),
    .rdData(rdData), .ackEn(ackEn), .ackVec(ackVec), .pendArr(pendArr)
  );

  typedef struct packed {
    logic        isWr;
    logic [1:0]  sel;
    logic [63:0] base;
    logic [63:0] data;
    logic [63:0] exp;
    logic [3:0]  req;
  } row_t;

  // R2 R3 R4 R13 table: reads check exp, writes only update state
  localparam row_t TBL [9] = '{
    '{1'b0, 2'd0, 64'd100, 64'd0,     64'd100,  4'd2},
    '{1'b0, 2'd0, 64'd90,  64'd0,     64'd100,  4'd3},
    '{1'b0, 2'd0, 64'd150, 64'd0,     64'd150,  4'd2},
    '{1'b1, 2'd0, 64'd200, 64'd1000,  64'd0,    4'd4},
    '{1'b0, 2'd0, 64'd205, 64'd0,     64'd1005, 4'd4},
    '{1'b1, 2'd1, 64'd210, 64'd5000,  64'd0,    4'd7},
    '{1'b0, 2'd1, 64'd210, 64'd0,     64'd5000, 4'd13},
    '{1'b1, 2'd2, 64'd210, 64'h23,    64'd0,    4'd11},
    '{1'b0, 2'd2, 64'd210, 64'd0,     64'h23,   4'd13}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] sel, output logic [63:0] v);
    @(negedge clk);
    rdEn = 1'b1; rdSel = sel;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic setBase(input logic [63:0] b);
    @(negedge clk);
    baseCount = b;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic checkBit(input int idx, input bit exp, input string req);
    check(pendArr[idx] == exp, req, {63'd0, pendArr[idx]}, {63'd0, exp});
  endtask

  task automatic checkNone(input string req);
    check(pendArr == '0, req, {55'd0, 9'($countones(pendArr))}, 64'd0);
  endtask

  initial begin
    logic [63:0] v;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkNone("R1 pending after reset");
    doRead(2'd1, v); check(v == 64'd0, "R1 match reset", v, 64'd0);
    doRead(2'd2, v); check(v == 64'h10000, "R1 vector reset", v, 64'h10000);

    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      baseCount = TBL[i].base;
      if (TBL[i].isWr) begin
        wrEn = 1'b1; wrSel = TBL[i].sel; wrData = TBL[i].data;
      end else begin
        rdEn = 1'b1; rdSel = TBL[i].sel;
      end
      @(negedge clk);
      wrEn = 1'b0; rdEn = 1'b0;
      if (!TBL[i].isWr) begin
        nChecks++;
        if (rdData != TBL[i].exp) begin
          nFails++;
          $display("FAIL R%0d row %0d actual=0x%0h expected=0x%0h",
                   TBL[i].req, i, rdData, TBL[i].exp);
        end
      end
    end

    // R8 fire exactly at the match, not one below
    setBase(64'd4199); checkBit(8'h23, 1'b0, "R8 below match");
    setBase(64'd4200); checkBit(8'h23, 1'b1, "R8 fire at match");
    // R12 acknowledge, and R8 no second firing
    @(negedge clk); ackEn = 1'b1; ackVec = 8'h23;
    @(negedge clk); ackEn = 1'b0;
    checkBit(8'h23, 1'b0, "R12 ack clears");
    setBase(64'd4300); idle(3);
    checkBit(8'h23, 1'b0, "R8 single firing");

    // R6 match write withdraws pending bit
    doWrite(2'd1, 64'd6000);
    setBase(64'd5200); checkBit(8'h23, 1'b1, "R8 rearmed fire");
    doWrite(2'd1, 64'd7000);
    checkBit(8'h23, 1'b0, "R6 match write clears");
    setBase(64'd6200);
    // R11 move on vector change
    doWrite(2'd2, 64'h31);
    check(pendArr[8'h23] == 1'b0 && pendArr[8'h31] == 1'b1, "R11 move",
          {62'd0, pendArr[8'h31], pendArr[8'h23]}, 64'd2);
    // R10 masking write clears
    doWrite(2'd2, 64'h10031);
    checkBit(8'h31, 1'b0, "R10 mask clears");
    doRead(2'd2, v); check(v == 64'h10031, "R13 vector readback", v, 64'h10031);

    // R9 masked firing sets nothing and consumes the arming
    doWrite(2'd1, 64'd8000);
    setBase(64'd7200); idle(1);
    checkNone("R9 masked fire");
    doWrite(2'd2, 64'h31); idle(2);
    checkNone("R9 no late fire after unmask");

    // R5 counter write past the match
    doWrite(2'd1, 64'd9000);
    setBase(64'd8200); checkBit(8'h31, 1'b1, "R8 fire before counter write");
    doWrite(2'd0, 64'd20000);
    checkBit(8'h31, 1'b0, "R5 counter write clears");
    doWrite(2'd1, 64'd25000);
    doWrite(2'd0, 64'd30000); idle(2);
    checkNone("R5 disarmed after counter write");

    // R7 match at or below last reported value stays disarmed
    doWrite(2'd1, 64'd29000); idle(3);
    checkNone("R7 no arm below last");
    doRead(2'd0, v); check(v == 64'd30000, "R4 counter after write", v, 64'd30000);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule